// File: doc/BRIEF.md
# Line PHY Management Register Bank

This block is the host-visible control and status bank for a cell-based line PHY. A small synchronous port with a 3-bit address and 8-bit data reaches seven registers: master control, event status, diagnostic/loopback control, LED/HEC control, and a set of three registers that read four 16-bit event counters.

The datapath reports events as one-cycle strobes. These are symbol error, transmitted cell, received cell, receive HEC error, short cell, transmit parity error and receive FIFO overrun. It also supplies a good-signal level that may arrive from another clock domain. Each event sets a sticky flag, and a read of the status register clears all the flags at once.

The counters saturate. To read one, the host writes a one-hot code to the select register. That write copies the chosen counter into a holding register and restarts the counter. The host then reads the two bytes of the holding register.

The block drives four outputs:
- an interrupt pin, gated by an enable bit
- a loopback mode code
- a one-cycle receive-FIFO flush pulse
- a halt-transmit level

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, every register reads 0x00. After reset, `irq`, `rx_flush`, `halt_tx` and `loop_mode` are all 0.
- R2: Each event strobe sets its flag in the status register (address 1), and the flag stays set until a status read. The flag bits are:
  - bit 5: HEC error
  - bit 4: short cell
  - bit 3: transmit parity error
  - bit 1: symbol error
  - bit 0: FIFO overrun
- R3: Status bit 6 shows the good-signal input after a two-stage synchronizer. A status read does not change it.
- R4: A status read returns the current value and clears all of bits 5..0 at the same clock edge. An event that arrives in the same cycle as the read is kept set.
- R5: `irq` is high while master control bit 0 is 1 and any sticky flag is set. `irq` falls in the cycle after a status read clears the flags.
- R6: Master control (address 0) reads back all 8 bits as written. `halt_tx` follows bit 2 of that register.
- R7: Writing 1 to diagnostic bit 4 (address 2) makes `rx_flush` high for exactly the following cycle. Bit 4 always reads 0, and the other diagnostic bits read back as written.
- R8: `loop_mode` decodes diagnostic bits 1..0 as follows:
  - 00 gives 0 (normal)
  - 10 gives 1 (local loopback)
  - 11 gives 2 (remote loopback)
  - 01 gives 0
- R9: Status bit 2 (signal change) is set by both a rising and a falling edge of the synchronized good signal.
- R10: A write to address 6 with exactly one of bits 3..0 set does three things in the same cycle:
  - it copies the selected counter into the holding register;
  - it clears that counter;
  - it stores the code, which reads back at address 6.

  The select codes are 0x08 symbol errors, 0x04 transmitted cells, 0x02 received cells and 0x01 HEC errors. Address 4 returns the low byte of the holding register and address 5 returns the high byte. An event in the same cycle as the select write leaves the restarted counter at 1.
- R11: A select write whose bits 3..0 are not one-hot has no effect. It does not change the holding register, any counter, or the stored select code.
- R12: Counters stop at 0xFFFF and do not wrap.
- R13: The LED/HEC register (address 3) keeps only bits 6..3; the others read 0. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (drives clear-on-read) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ev_sym_err | input | 1 | Symbol error strobe |
| ev_tx_cell | input | 1 | Transmitted cell strobe |
| ev_rx_cell | input | 1 | Received cell strobe |
| ev_hec_err | input | 1 | Receive HEC error strobe |
| ev_short_cell | input | 1 | Short cell strobe |
| ev_tx_par_err | input | 1 | Transmit parity error strobe |
| ev_fifo_ovr | input | 1 | Receive FIFO overrun strobe |
| good_sig_in | input | 1 | Asynchronous good-signal level |
| irq | output | 1 | Interrupt pin |
| loop_mode | output | 2 | Loopback mode: 0 normal, 1 local, 2 remote |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| halt_tx | output | 1 | Halt transmit |

## Verification
The counters are driven by four interleaved periodic strobe patterns. Each pattern uses a distinct modulus and the bench runs two run lengths. Each counter therefore ends at a different, arithmetically known value, which shows up swapped select codes, swapped bytes, or counting on the wrong strobe.

Each sticky source is tested alone, which tells the bit positions apart. Both edges of the good signal are tested to separate the live bit from the change flag.

Three corner cases get their own checks:
- an event arriving in the same cycle as a select write or a status read
- a select code that is not one-hot
- a long continuous strobe that drives a counter past saturation

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int CNT_W = 2 * DW;
    localparam int NCNT  = 4;
    localparam int NSTK  = 6;

    typedef enum logic [AW-1:0] {
        A_MCR  = 3'd0,
        A_STAT = 3'd1,
        A_DIAG = 3'd2,
        A_LED  = 3'd3,
        A_CLO  = 3'd4,
        A_CHI  = 3'd5,
        A_SEL  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'd0,
        LB_LOCAL  = 2'd1,
        LB_REMOTE = 2'd2
    } lb_mode_e;

    localparam logic [DW-1:0] LED_MASK  = 8'h78;
    localparam logic [DW-1:0] DIAG_MASK = 8'hEF;
    localparam int DIAG_FLUSH_BIT = 4;
    localparam int MCR_IRQ_EN_BIT = 0;
    localparam int MCR_HALT_BIT   = 2;

    typedef struct packed {
        logic [DW-1:0]    mcr;
        logic [DW-1:0]    diag;
        logic [DW-1:0]    led;
        logic [NCNT-1:0]  sel;
        logic [CNT_W-1:0] hold;
        logic [NSTK-1:0]  sticky;
        logic             flush;
    } regs_t;
endpackage

// File: rtl/phy_sig_sync.sv
module phy_sig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic sig_lvl,
    output logic sig_edge
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sig_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sig_lvl  = sh_q[STAGES-1];
    assign sig_edge = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/phy_evt_counter.sv
module phy_evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = inc ? W'(1) : '0;
        else if (inc && cnt_q != CMAX)
            cnt_d = cnt_q + W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          ev_sym_err,
    input  logic          ev_tx_cell,
    input  logic          ev_rx_cell,
    input  logic          ev_hec_err,
    input  logic          ev_short_cell,
    input  logic          ev_tx_par_err,
    input  logic          ev_fifo_ovr,
    input  logic          good_sig_in,
    output logic          irq,
    output logic [1:0]    loop_mode,
    output logic          rx_flush,
    output logic          halt_tx
);
    regs_t st_d, st_q;

    logic             sig_lvl, sig_edge;
    logic [NCNT-1:0]  cnt_inc, cnt_clr;
    logic [CNT_W-1:0] cnt_val [NCNT];
    logic [NSTK-1:0]  stk_set;
    logic [NSTK-1:0]  sticky_now;
    logic             sel_ok;

    phy_sig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sig_in(good_sig_in),
        .sig_lvl(sig_lvl), .sig_edge(sig_edge)
    );

    // counter index equals the select bit position
    assign cnt_inc = {ev_sym_err, ev_tx_cell, ev_rx_cell, ev_hec_err};

    generate
        for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
            phy_evt_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .inc(cnt_inc[gi]),
                .clr(cnt_clr[gi]), .cnt(cnt_val[gi])
            );
        end
    endgenerate

    assign stk_set = {ev_hec_err, ev_short_cell, ev_tx_par_err,
                      sig_edge, ev_sym_err, ev_fifo_ovr};

    assign sel_ok  = wr_en && (addr == A_SEL) && $onehot(wdata[NCNT-1:0]);
    assign cnt_clr = sel_ok ? wdata[NCNT-1:0] : '0;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (wr_en) begin
            case (addr)
                A_MCR:  st_d.mcr = wdata;
                A_DIAG: begin
                    st_d.diag  = wdata & DIAG_MASK;
                    st_d.flush = wdata[DIAG_FLUSH_BIT];
                end
                A_LED:  st_d.led = wdata & LED_MASK;
                default: ;
            endcase
        end
        if (sel_ok) begin
            st_d.sel = wdata[NCNT-1:0];
            for (int i = 0; i < NCNT; i++)
                if (wdata[i]) st_d.hold = cnt_val[i];
        end
        if (rd_en && addr == A_STAT)
            st_d.sticky = stk_set;
        else
            st_d.sticky = st_q.sticky | stk_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_MCR:   rdata = st_q.mcr;
            A_STAT:  rdata = {1'b0, sig_lvl, st_q.sticky};
            A_DIAG:  rdata = st_q.diag;
            A_LED:   rdata = st_q.led;
            A_CLO:   rdata = st_q.hold[DW-1:0];
            A_CHI:   rdata = st_q.hold[CNT_W-1:DW];
            A_SEL:   rdata = {{(DW-NCNT){1'b0}}, st_q.sel};
            default: rdata = '0;
        endcase
    end

    always_comb begin
        case (st_q.diag[1:0])
            2'b10:   loop_mode = LB_LOCAL;
            2'b11:   loop_mode = LB_REMOTE;
            default: loop_mode = LB_NORMAL;
        endcase
    end

    assign sticky_now = st_q.sticky;
    assign irq        = st_q.mcr[MCR_IRQ_EN_BIT] && (|sticky_now);
    assign rx_flush   = st_q.flush;
    assign halt_tx    = st_q.mcr[MCR_HALT_BIT];
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       ev_fifo_ovr,
    input logic       ev_hec_err,
    input logic       ev_short_cell,
    input logic       ev_tx_par_err,
    input logic       ev_sym_err,
    input logic       irq,
    input logic       rx_flush,
    input logic       halt_tx,
    input logic [1:0] loop_mode,
    input logic [5:0] sticky_now
);
    a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fifo_ovr |=> sticky_now[0]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd1 && !ev_fifo_ovr && !ev_hec_err && !ev_short_cell
         && !ev_tx_par_err && !ev_sym_err) |=> ((sticky_now & 6'b111011) == 6'b0));

    a_r5_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !wdata[0]) |=> !irq);

    a_r6_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> (halt_tx == $past(wdata[2])));

    a_r7_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && wdata[4]) |=> rx_flush);

    a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(wr_en && addr == 3'd2 && wdata[4]));

    a_r8_loop_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode != 2'd3);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ev_fifo_ovr(ev_fifo_ovr), .ev_hec_err(ev_hec_err),
    .ev_short_cell(ev_short_cell), .ev_tx_par_err(ev_tx_par_err),
    .ev_sym_err(ev_sym_err), .irq(irq), .rx_flush(rx_flush),
    .halt_tx(halt_tx), .loop_mode(loop_mode), .sticky_now(sticky_now)
);

// File: tb/phy_mgmt_regs_tb.sv
`timescale 1ns/1ps
module phy_mgmt_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ev_sym_err = 0, ev_tx_cell = 0, ev_rx_cell = 0, ev_hec_err = 0;
    logic       ev_short_cell = 0, ev_tx_par_err = 0, ev_fifo_ovr = 0, good_sig_in = 0;
    logic       irq, rx_flush, halt_tx;
    logic [1:0] loop_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_sym_err(ev_sym_err),
        .ev_tx_cell(ev_tx_cell), .ev_rx_cell(ev_rx_cell), .ev_hec_err(ev_hec_err),
        .ev_short_cell(ev_short_cell), .ev_tx_par_err(ev_tx_par_err),
        .ev_fifo_ovr(ev_fifo_ovr), .good_sig_in(good_sig_in), .irq(irq),
        .loop_mode(loop_mode), .rx_flush(rx_flush), .halt_tx(halt_tx)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic read_cnt(input int idx, output int v);
        logic [7:0] lo, hi;
        wr(3'd6, 8'(1 << idx));
        rd(3'd4, lo);
        rd(3'd5, hi);
        v = {hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R0 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int c;
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reg %0d reset", a), v, 0);
        end
        check("R1 outputs reset", {irq, rx_flush, halt_tx, loop_mode}, 0);

        // R6 master control readback and halt
        wr(3'd0, 8'hA4);
        rd(3'd0, v); check("R6 mcr readback", v, 8'hA4);
        check("R6 halt_tx high", halt_tx, 1);
        wr(3'd0, 8'h00);
        check("R6 halt_tx low", halt_tx, 0);

        // R13 LED/HEC mask, unused address
        wr(3'd3, 8'hFF);
        rd(3'd3, v); check("R13 led mask", v, 8'h78);
        wr(3'd7, 8'hFF);
        rd(3'd7, v); check("R13 addr7 reads zero", v, 0);

        // R7 flush pulse and diag readback
        @(negedge clk); wr_en = 1; addr = 3'd2; wdata = 8'hF3;
        @(negedge clk); wr_en = 0;
        check("R7 flush pulse", rx_flush, 1);
        @(negedge clk);
        check("R7 flush ends", rx_flush, 0);
        rd(3'd2, v); check("R7 diag bit4 reads 0", v, 8'hE3);

        // R8 loop decode over all codes
        for (int k = 0; k < 4; k++) begin
            wr(3'd2, 8'(k));
            check($sformatf("R8 loop code %0d", k), loop_mode,
                  (k == 2) ? 1 : (k == 3) ? 2 : 0);
        end
        wr(3'd2, 8'h00);

        // R2 / R4 each sticky source alone
        for (int b = 0; b < 6; b++) begin
            if (b == 2) continue;
            @(negedge clk);
            ev_fifo_ovr = (b == 0); ev_sym_err = (b == 1); ev_tx_par_err = (b == 3);
            ev_short_cell = (b == 4); ev_hec_err = (b == 5);
            @(negedge clk);
            {ev_fifo_ovr, ev_sym_err, ev_tx_par_err, ev_short_cell, ev_hec_err} = '0;
            idle(2);
            rd(3'd1, v); check($sformatf("R2 sticky bit %0d", b), v, 1 << b);
            rd(3'd1, v); check($sformatf("R4 cleared bit %0d", b), v, 0);
        end
        // clear the symbol-error count produced above
        read_cnt(3, c);
        read_cnt(0, c);

        // R4 event in same cycle as status read survives
        @(negedge clk); rd_en = 1; addr = 3'd1; ev_short_cell = 1;
        @(negedge clk); rd_en = 0; ev_short_cell = 0;
        rd(3'd1, v); check("R4 same-cycle event kept", v, 8'h10);

        // R5 interrupt gating
        wr(3'd0, 8'h01);
        check("R5 irq idle", irq, 0);
        @(negedge clk); ev_fifo_ovr = 1;
        @(negedge clk); ev_fifo_ovr = 0;
        check("R5 irq asserted", irq, 1);
        wr(3'd0, 8'h00);
        check("R5 irq masked", irq, 0);
        wr(3'd0, 8'h01);
        check("R5 irq re-enabled", irq, 1);
        rd(3'd1, v);
        check("R5 irq drops after read", irq, 0);
        wr(3'd0, 8'h00);

        // R3 / R9 good signal level and edges
        @(negedge clk); good_sig_in = 1;
        idle(4);
        rd(3'd1, v); check("R9 rising edge flag", v, 8'h44);
        rd(3'd1, v); check("R3 level survives read", v, 8'h40);
        @(negedge clk); good_sig_in = 0;
        idle(4);
        rd(3'd1, v); check("R9 falling edge flag", v, 8'h04);

        // R10 counter sweep, two run lengths
        for (int r = 0; r < 2; r++) begin
            int len = (r == 0) ? 60 : 97;
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                ev_hec_err = (i % 2 == 0); ev_rx_cell = (i % 3 == 0);
                ev_tx_cell = (i % 4 == 0); ev_sym_err = (i % 5 == 0);
            end
            @(negedge clk);
            {ev_hec_err, ev_rx_cell, ev_tx_cell, ev_sym_err} = '0;
            for (int j = 0; j < 4; j++) begin
                read_cnt(j, c);
                check($sformatf("R10 counter %0d len %0d", j, len), c, (len + j + 1) / (j + 2));
            end
            rd(3'd1, v);
        end
        rd(3'd6, v); check("R10 select readback", v, 8'h08);

        // R10 event during select write restarts at 1
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ev_rx_cell = 1;
            @(negedge clk); ev_rx_cell = 0;
        end
        @(negedge clk); wr_en = 1; addr = 3'd6; wdata = 8'h02; ev_rx_cell = 1;
        @(negedge clk); wr_en = 0; ev_rx_cell = 0;
        rd(3'd4, v); check("R10 captured before restart", v, 3);
        read_cnt(1, c); check("R10 restarted counter is 1", c, 1);

        // R11 non-one-hot select ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ev_tx_cell = 1;
            @(negedge clk); ev_tx_cell = 0;
        end
        wr(3'd6, 8'h06);
        rd(3'd4, v); check("R11 hold unchanged", v, 1);
        rd(3'd6, v); check("R11 select unchanged", v, 8'h02);
        read_cnt(2, c); check("R11 counter not cleared", c, 5);

        // R12 saturation
        @(negedge clk); ev_tx_cell = 1;
        idle(65540);
        ev_tx_cell = 0;
        read_cnt(2, c); check("R12 saturates", c, 16'hFFFF);
        read_cnt(2, c); check("R12 cleared after read", c, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule